// File: doc/BRIEF.md
# Indirect Register Addressing Unit

This block sits between an instruction decoder and an 8-bit register file. It turns the register operand of each instruction into a 9-bit register-file address. An operand that names the virtual pointer register is not stored anywhere. Such an access is sent to the location held in the file-select pointer instead, and a separate bank bit from the status register is placed above the pointer to form the ninth address bit. Every other operand is passed through with the direct-mode bank bits placed above it.

When the pointer itself selects the virtual register, the access refers to itself. A read of this kind returns zero. A write of this kind is dropped before it reaches the register file. The unit is purely combinational. The register file sees the final address, data and write enable in the same cycle that the operand is presented.

Top module: `indirect_addr_unit`

## Requirements
- R1: An operand whose low 7 bits are zero is treated as indirect in every bank, whatever the value of `bank_sel`.
- R2: For an indirect access, `rf_addr[8]` equals `ind_bank` and `rf_addr[7:0]` equals `ptr`.
- R3: An indirect read whose pointer has its low 7 bits at zero (pointer 00h or 80h, with either value of `ind_bank`) returns 00h on `rd_data`, whatever the register file presents.
- R4: An indirect write whose pointer has its low 7 bits at zero keeps `rf_we` low, so no register-file location changes.
- R5: For a non-indirect operand, `rf_addr` equals `{bank_sel, op_addr}`, `rf_we` follows `wr_req`, and `rd_data` equals `rf_rdata`.
- R6: For an indirect access that does not refer to itself, `rf_we` follows `wr_req` and `rd_data` equals `rf_rdata`.
- R7: `rf_wdata` always equals `wr_data`.
- R8: Loading the pointer with 20h and then writing zero through the indirect operand 16 times, adding one to the pointer after each write, clears locations 20h through 2Fh and leaves 1Fh and 30h unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_addr | input | 7 | Register operand field from the instruction |
| bank_sel | input | 2 | Direct-mode bank bits |
| wr_req | input | 1 | The instruction writes its register operand |
| wr_data | input | 8 | Data to be written |
| ptr | input | 8 | File-select pointer value |
| ind_bank | input | 1 | Status bank bit used for indirect accesses |
| rf_rdata | input | 8 | Read data from the register file at `rf_addr` |
| rf_addr | output | 9 | Resolved register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 8 | Register-file write data |
| rd_data | output | 8 | Operand read data returned to the datapath |

## Verification
The hardest case to reach from the ports is a self-referencing access through a mirror of the virtual register: pointer 80h, or pointer 00h with the indirect bank bit set. The bench first preloads those locations in its register-file model with a non-zero value. It then issues both a read and a write there. It checks that the read returns zero even though the model drives a non-zero value, and that the preloaded value is still present after the clock edge. The clearing loop is run against the same model and read back with direct operands, so that the neighbouring locations show any write that strayed outside the loop's range.

// File: rtl/indirect_addr_unit.sv
module indirect_addr_unit #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 7,
  parameter int PTR_W  = 8,
  localparam int ADDR_W = PTR_W + 1,
  localparam int BANK_W = ADDR_W - OP_W
) (
  input  logic [OP_W-1:0]   op_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              ind_bank,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [DATA_W-1:0] rd_data
);

  logic use_ptr;
  logic self_ref;

  assign use_ptr  = (op_addr == '0);
  assign self_ref = use_ptr && (ptr[OP_W-1:0] == '0);

  assign rf_addr  = use_ptr ? {ind_bank, ptr} : {bank_sel, op_addr};
  assign rf_we    = wr_req && !self_ref;
  assign rf_wdata = wr_data;
  assign rd_data  = self_ref ? '0 : rf_rdata;

endmodule

module indirect_addr_unit_chk #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 7,
  parameter int PTR_W  = 8,
  localparam int ADDR_W = PTR_W + 1,
  localparam int BANK_W = ADDR_W - OP_W
) (
  input logic [OP_W-1:0]   op_addr,
  input logic [BANK_W-1:0] bank_sel,
  input logic              wr_req,
  input logic [DATA_W-1:0] wr_data,
  input logic [PTR_W-1:0]  ptr,
  input logic              ind_bank,
  input logic [DATA_W-1:0] rf_rdata,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [DATA_W-1:0] rd_data
);

  logic known;
  assign known = !$isunknown({op_addr, bank_sel, wr_req, wr_data, ptr, ind_bank, rf_rdata});

  always_comb begin
    if (known) begin
      if (op_addr == '0) begin
        p_ind_addr_r1: assert (rf_addr[ADDR_W-1] == ind_bank && rf_addr[PTR_W-1:0] == ptr);
        if (ptr[OP_W-1:0] == '0) begin
          p_self_rd_zero_r3: assert (rd_data == '0);
          p_self_no_we_r4:   assert (!rf_we);
        end else begin
          p_ind_pass_r6: assert (rf_we == wr_req && rd_data == rf_rdata);
        end
      end else begin
        p_direct_pass_r5: assert (rf_addr[OP_W-1:0] == op_addr && rf_addr[ADDR_W-1:OP_W] == bank_sel
                                  && rf_we == wr_req && rd_data == rf_rdata);
      end
      p_we_needs_req_r6: assert (!rf_we || wr_req);
      p_wdata_r7:        assert (rf_wdata == wr_data);
    end
  end

endmodule

bind indirect_addr_unit indirect_addr_unit_chk #(
  .DATA_W(DATA_W), .OP_W(OP_W), .PTR_W(PTR_W)
) u_chk (
  .op_addr(op_addr), .bank_sel(bank_sel), .wr_req(wr_req), .wr_data(wr_data),
  .ptr(ptr), .ind_bank(ind_bank), .rf_rdata(rf_rdata), .rf_addr(rf_addr),
  .rf_we(rf_we), .rf_wdata(rf_wdata), .rd_data(rd_data)
);

// File: tb/indirect_addr_unit_tb.sv
module indirect_addr_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] op_addr = '0;
  logic [1:0] bank_sel = '0;
  logic       wr_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ptr = '0;
  logic       ind_bank = 1'b0;
  logic [7:0] rf_rdata;
  logic [8:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rd_data;

  logic [7:0] mem [512];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  indirect_addr_unit u_dut (
    .op_addr(op_addr), .bank_sel(bank_sel), .wr_req(wr_req), .wr_data(wr_data),
    .ptr(ptr), .ind_bank(ind_bank), .rf_rdata(rf_rdata), .rf_addr(rf_addr),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rd_data(rd_data)
  );

  assign rf_rdata = mem[rf_addr];

  always @(posedge clk) begin
    if (rst_n && rf_we) mem[rf_addr] <= rf_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] a, input logic [1:0] b, input logic w,
                       input logic [7:0] d, input logic [7:0] p, input logic ib);
    @(negedge clk);
    op_addr = a; bank_sel = b; wr_req = w; wr_data = d; ptr = p; ind_bank = ib;
    #2;
  endtask

  task automatic t_reset;
    drive(7'h10, 2'd0, 1'b0, 8'h00, 8'h00, 1'b0);
    check(rf_we == 1'b0, "R5 idle we", rf_we, 0);
  endtask

  task automatic t_direct;
    drive(7'h25, 2'd2, 1'b1, 8'h5A, 8'h33, 1'b1);
    check(rf_addr == 9'h125, "R5 direct addr", rf_addr, 9'h125);
    check(rf_we == 1'b1, "R5 direct we", rf_we, 1);
    check(rf_wdata == 8'h5A, "R7 wdata", rf_wdata, 8'h5A);
    drive(7'h25, 2'd2, 1'b0, 8'hA5, 8'h33, 1'b1);
    check(rd_data == 8'h5A, "R5 direct readback", rd_data, 8'h5A);
    check(rf_wdata == 8'hA5, "R7 wdata idle", rf_wdata, 8'hA5);
  endtask

  task automatic t_indirect;
    drive(7'h00, 2'd3, 1'b1, 8'hC3, 8'h33, 1'b1);
    check(rf_addr == 9'h133, "R2 eff addr", rf_addr, 9'h133);
    check(rf_we == 1'b1, "R6 ind we", rf_we, 1);
    drive(7'h00, 2'd1, 1'b0, 8'h00, 8'h33, 1'b0);
    check(rf_addr == 9'h033, "R1 ind in bank1", rf_addr, 9'h033);
    drive(7'h33, 2'd2, 1'b0, 8'h00, 8'h00, 1'b0);
    check(rd_data == 8'hC3, "R2 direct sees ind write", rd_data, 8'hC3);
    drive(7'h00, 2'd0, 1'b0, 8'h00, 8'hB3, 1'b1);
    check(rf_addr == 9'h1B3, "R2 high ptr", rf_addr, 9'h1B3);
    check(rd_data == mem[9'h1B3], "R6 ind read", rd_data, mem[9'h1B3]);
  endtask

  task automatic t_self;
    foreach (mem[i]) if (i[6:0] == 7'h0) mem[i] = 8'h77;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] p = (k % 2) ? 8'h80 : 8'h00;
      logic ib = (k >= 2);
      drive(7'h00, k[1:0], 1'b0, 8'h00, p, ib);
      check(rd_data == 8'h00, "R3 self read zero", rd_data, 0);
      drive(7'h00, k[1:0], 1'b1, 8'h12, p, ib);
      check(rf_we == 1'b0, "R4 self write we", rf_we, 0);
      @(posedge clk); #1;
      check(mem[{ib, p}] == 8'h77, "R4 self write no change", mem[{ib, p}], 8'h77);
    end
  endtask

  task automatic t_clear;
    for (int a = 8'h1F; a <= 8'h30; a++) mem[a] = 8'hFF;
    for (int p = 8'h20; p <= 8'h2F; p++) begin
      drive(7'h00, 2'd0, 1'b1, 8'h00, p[7:0], 1'b0);
      @(posedge clk);
    end
    for (int a = 8'h1F; a <= 8'h30; a++) begin
      logic [7:0] exp = (a == 8'h1F || a == 8'h30) ? 8'hFF : 8'h00;
      drive(a[6:0], 2'd0, 1'b0, 8'h00, 8'h00, 1'b0);
      check(rd_data == exp, "R8 clear loop", rd_data, exp);
    end
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_indirect();
    t_self();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule